// File: doc/BRIEF.md
# Alarm Indication Signal Detector for DS3 and E3 Receive Streams

This block sits behind a receive framer and decides whether the incoming stream carries an Alarm Indication Signal. The framer has already found alignment. It hands over one data bit per asserted bit enable, along with these qualifiers:

- which bits are payload, C-bits or X-bits;
- where each frame and each M-frame begins;
- whether it is currently in frame.

A single mode input picks one of two detection rules.

In DS3 mode the block judges whole M-frames. A qualifying M-frame meets three conditions:

- its payload bits alternate between one and zero without a break;
- every C-bit is zero and every X-bit is one;
- in-frame status was never lost during it.

A long unbroken run of qualifying M-frames raises the flag. A short run of failing M-frames drops it. In E3 mode the block counts zero bits in each frame. Two qualifying frames in a row raise the flag, and a single frame with too many zeros drops it.

Each verdict covers the frame that has just ended. It is applied on the bit enable that carries the next frame's start marker, and the flag is a register that changes only then or on a mode change.

Top module: `ais_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the flag `ais` is 0 and all run counts are cleared.
- R2: In DS3 mode `ais` becomes 1 on the boundary (bit enable with `mframe_start`) that completes the 63rd consecutive qualifying M-frame, and not on any earlier boundary.
- R3: In DS3 mode the payload bits of an M-frame must alternate. The first payload bit after `mframe_start` may be 1 or 0 and fixes the phase for that M-frame. Two equal payload bits in a row make the M-frame non-qualifying.
- R4: In DS3 mode an M-frame with any C-bit equal to 1 or any X-bit equal to 0 is non-qualifying, and it restarts the qualifying run count from zero.
- R5: In DS3 mode `ais` returns to 0 on the boundary that completes the 2nd consecutive non-qualifying M-frame. A qualifying M-frame in between restarts that count.
- R6: In E3 mode `ais` becomes 1 on the boundary (bit enable with `frame_start`) that completes the 2nd consecutive frame holding 7 or fewer zero bits. A frame with exactly 7 zeros qualifies.
- R7: In E3 mode a single frame holding 8 or more zero bits returns `ais` to 0 on the boundary that completes it.
- R8: When `mode_sel` changes (0 = DS3, 1 = E3), `ais` is 0 in the next cycle and all counts restart. After the change, and after reset, the partly seen frame that ends at the first boundary is not judged.
- R9: A frame or M-frame during which `in_frame` was 0 on any enabled bit is non-qualifying.
- R10: `ais` changes only in the cycle after a boundary of the selected mode or after a mode change. Cycles with `bit_en` at 0 have no effect, whatever the data and qualifiers carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | A valid receive bit is present this cycle |
| data_in | input | 1 | Receive data bit |
| mode_sel | input | 1 | 0 selects the DS3 rule, 1 selects the E3 rule |
| is_payload | input | 1 | Current bit is a DS3 payload bit |
| is_cbit | input | 1 | Current bit is a DS3 C-bit |
| is_xbit | input | 1 | Current bit is a DS3 X-bit |
| frame_start | input | 1 | Current bit is the first bit of a frame |
| mframe_start | input | 1 | Current bit is the first bit of a DS3 M-frame |
| in_frame | input | 1 | Upstream framer reports alignment |
| ais | output | 1 | Registered Alarm Indication Signal flag |

## Verification
A corrupted run count or a lost alternation phase does not show on `ais` right away. It shows at the boundary where the flag should have risen or fallen, which can be up to 63 M-frames later in DS3 mode. For that reason the bench runs sequences long enough to cross each threshold exactly, and places faults just before the threshold. An accumulator that fails to restart at a frame start shows up one boundary later, when a good frame is wrongly judged bad or the reverse. A flag that moves between boundaries is caught in the very cycle it moves, because the reference model is compared on every clock.

// File: rtl/ais_pkg.sv
package ais_pkg;
   typedef enum logic {
      AIS_MODE_DS3 = 1'b0,
      AIS_MODE_E3  = 1'b1
   } ais_mode_e;

   function automatic int ais_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ais_sat_count.sv
module ais_sat_count #(
   parameter int LIMIT = 63,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("ais_sat_count: LIMIT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (clr)                 count <= '0;
      else if (inc && count != TOP) count <= count + 1'b1;
   end
endmodule

// File: rtl/ais_ds3_acc.sv
module ais_ds3_acc (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic bit_en,
   input  logic data_in,
   input  logic start,
   input  logic is_payload,
   input  logic is_cbit,
   input  logic is_xbit,
   input  logic in_frame,
   output logic frame_ok
);
   logic ok_q, phase_q, last_q;
   logic base_ok, base_phase, bit_ok;

   // a start bit opens a fresh M-frame and is judged as its first bit
   always_comb begin
      base_ok    = start ? 1'b1 : ok_q;
      base_phase = start ? 1'b0 : phase_q;
      bit_ok     = in_frame
                   && !(is_cbit && data_in)
                   && !(is_xbit && !data_in)
                   && !(is_payload && base_phase && (data_in == last_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q    <= 1'b1;
         phase_q <= 1'b0;
         last_q  <= 1'b0;
      end else if (restart) begin
         ok_q    <= 1'b1;
         phase_q <= 1'b0;
      end else if (bit_en) begin
         ok_q <= base_ok && bit_ok;
         if (is_payload) begin
            phase_q <= 1'b1;
            last_q  <= data_in;
         end else begin
            phase_q <= base_phase;
         end
      end
   end

   assign frame_ok = ok_q;
endmodule

// File: rtl/ais_e3_acc.sv
module ais_e3_acc #(
   parameter int MAX_ZEROS = 7,
   localparam int ZW = $clog2(MAX_ZEROS + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic bit_en,
   input  logic data_in,
   input  logic start,
   input  logic in_frame,
   output logic frame_ok
);
   localparam logic [ZW-1:0] ZSAT = ZW'(MAX_ZEROS + 1);

   logic [ZW-1:0] zeros_q, zeros_base;
   logic          inf_q, inf_base;

   assign zeros_base = start ? '0 : zeros_q;
   assign inf_base   = start ? 1'b1 : inf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zeros_q <= '0;
         inf_q   <= 1'b1;
      end else if (restart) begin
         zeros_q <= '0;
         inf_q   <= 1'b1;
      end else if (bit_en) begin
         inf_q   <= inf_base && in_frame;
         zeros_q <= (!data_in && zeros_base != ZSAT) ? zeros_base + 1'b1 : zeros_base;
      end
   end

   assign frame_ok = inf_q && (zeros_q < ZSAT);
endmodule

// File: rtl/ais_detector.sv
module ais_detector #(
   parameter int DS3_SET_MFRAMES = 63,
   parameter int DS3_CLR_MFRAMES = 2,
   parameter int E3_MAX_ZEROS    = 7,
   parameter int E3_SET_FRAMES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic data_in,
   input  logic mode_sel,
   input  logic is_payload,
   input  logic is_cbit,
   input  logic is_xbit,
   input  logic frame_start,
   input  logic mframe_start,
   input  logic in_frame,
   output logic ais
);
   import ais_pkg::*;

   localparam int SET_LIM = ais_max(DS3_SET_MFRAMES, E3_SET_FRAMES);
   localparam int SET_W   = $clog2(SET_LIM + 1);
   localparam int CLR_W   = $clog2(DS3_CLR_MFRAMES + 1);

   if (DS3_SET_MFRAMES < 1 || E3_SET_FRAMES < 1) begin : g_bad_set
      $error("ais_detector: set thresholds must be at least 1");
   end
   if (DS3_CLR_MFRAMES < 1) begin : g_bad_clr
      $error("ais_detector: DS3 clear threshold must be at least 1");
   end
   if (E3_MAX_ZEROS < 0) begin : g_bad_zeros
      $error("ais_detector: E3 zero limit must not be negative");
   end

   ais_mode_e        mode_e;
   logic             mode_q, mode_chg, seen_q;
   logic             bnd, eval, good, set_hit, clr_hit;
   logic             ds3_ok, e3_ok;
   logic [SET_W-1:0] set_cnt;
   logic [CLR_W-1:0] clr_cnt;
   int               set_lim;

   assign mode_e   = ais_mode_e'(mode_sel);
   assign mode_chg = (mode_sel != mode_q);
   assign bnd      = bit_en && !mode_chg
                     && ((mode_e == AIS_MODE_E3) ? frame_start : mframe_start);
   assign eval     = bnd && seen_q;
   assign good     = (mode_e == AIS_MODE_E3) ? e3_ok : ds3_ok;
   assign set_lim  = (mode_e == AIS_MODE_E3) ? E3_SET_FRAMES : DS3_SET_MFRAMES;
   assign set_hit  = (int'(set_cnt) + 1) >= set_lim;
   assign clr_hit  = (int'(clr_cnt) + 1) >= DS3_CLR_MFRAMES;

   ais_ds3_acc u_ds3 (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (mode_chg),
      .bit_en     (bit_en),
      .data_in    (data_in),
      .start      (mframe_start),
      .is_payload (is_payload),
      .is_cbit    (is_cbit),
      .is_xbit    (is_xbit),
      .in_frame   (in_frame),
      .frame_ok   (ds3_ok)
   );

   ais_e3_acc #(.MAX_ZEROS(E3_MAX_ZEROS)) u_e3 (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (mode_chg),
      .bit_en   (bit_en),
      .data_in  (data_in),
      .start    (frame_start),
      .in_frame (in_frame),
      .frame_ok (e3_ok)
   );

   ais_sat_count #(.LIMIT(SET_LIM)) u_set_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mode_chg || (eval && !good)),
      .inc   (eval && good),
      .count (set_cnt)
   );

   ais_sat_count #(.LIMIT(DS3_CLR_MFRAMES)) u_clr_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mode_chg || (eval && good)),
      .inc   (eval && !good && (mode_e == AIS_MODE_DS3)),
      .count (clr_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         seen_q <= 1'b0;
         ais    <= 1'b0;
      end else begin
         mode_q <= mode_sel;
         if (mode_chg) begin
            seen_q <= 1'b0;
            ais    <= 1'b0;
         end else begin
            if (bnd) seen_q <= 1'b1;
            if (eval) begin
               if (good && set_hit)
                  ais <= 1'b1;
               else if (!good && ((mode_e == AIS_MODE_E3) || clr_hit))
                  ais <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
   parameter int DS3_SET = 63,
   parameter int SET_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             mode_sel,
   input logic             frame_start,
   input logic             mframe_start,
   input logic             ais,
   input logic             mode_q,
   input logic             seen_q,
   input logic             e3_ok,
   input logic [SET_W-1:0] set_cnt
);
   // R10: without a boundary and with a steady mode the flag holds
   a_r10_hold_off_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bit_en && (mode_sel ? frame_start : mframe_start)) && mode_sel == mode_q)
      |=> $stable(ais));

   // R8: a mode change clears the flag in the next cycle
   a_r8_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != mode_q) |=> !ais);

   // R7: a judged E3 frame with too many zeros drops the flag
   a_r7_e3_bad_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel && mode_sel == mode_q && bit_en && frame_start && seen_q && !e3_ok)
      |=> !ais);

   // R2: in DS3 mode the flag rises only once the run is one short of the threshold
   a_r2_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ais) && !mode_sel) |-> (int'($past(set_cnt)) + 1 >= DS3_SET));

   // R1: the flag is low in the first cycle after reset
   a_r1_low_after_reset: assert property (@(posedge clk)
      !rst_n |=> !ais);
endmodule

bind ais_detector ais_detector_chk #(.DS3_SET(DS3_SET_MFRAMES), .SET_W(SET_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bit_en       (bit_en),
   .mode_sel     (mode_sel),
   .frame_start  (frame_start),
   .mframe_start (mframe_start),
   .ais          (ais),
   .mode_q       (mode_q),
   .seen_q       (seen_q),
   .e3_ok        (e3_ok),
   .set_cnt      (set_cnt)
);

// File: tb/test_ais_detector.sv
module test_ais_detector;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, data_in = 1'b0, mode_sel = 1'b0;
   logic is_payload = 1'b0, is_cbit = 1'b0, is_xbit = 1'b0;
   logic frame_start = 1'b0, mframe_start = 1'b0, in_frame = 1'b1;
   logic ais;

   int total = 0, bad = 0, cycles = 0;
   bit done = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   ais_detector i_ais_detector (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
      .mode_sel(mode_sel), .is_payload(is_payload), .is_cbit(is_cbit),
      .is_xbit(is_xbit), .frame_start(frame_start), .mframe_start(mframe_start),
      .in_frame(in_frame), .ais(ais)
   );

   // behavioural reference model
   bit m_ais = 0, m_prev = 0, m_seen = 0, m_dok = 1, m_have = 0, m_last = 0, m_einf = 1;
   int m_z = 0, m_run = 0, m_miss = 0;

   task automatic model_clear();
      m_seen = 0; m_dok = 1; m_have = 0; m_z = 0; m_einf = 1; m_run = 0; m_miss = 0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_prev = 0; m_ais = 0; m_last = 0; model_clear();
      end else if (mode_sel != m_prev) begin
         m_prev = mode_sel; m_ais = 0; model_clear();
      end else if (bit_en) begin
         if (mode_sel ? frame_start : mframe_start) begin
            if (m_seen) begin
               bit good;
               good = mode_sel ? (m_z <= 7 && m_einf) : m_dok;
               if (good) begin
                  m_run++; m_miss = 0;
                  if (m_run >= (mode_sel ? 2 : 63)) m_ais = 1;
               end else begin
                  m_run = 0; m_miss++;
                  if (mode_sel || m_miss >= 2) m_ais = 0;
               end
            end
            m_seen = 1;
         end
         if (mframe_start) begin m_dok = 1; m_have = 0; end
         if (!in_frame) m_dok = 0;
         if (is_cbit && data_in) m_dok = 0;
         if (is_xbit && !data_in) m_dok = 0;
         if (is_payload) begin
            if (m_have && data_in == m_last) m_dok = 0;
            m_have = 1; m_last = data_in;
         end
         if (frame_start) begin m_z = 0; m_einf = 1; end
         if (!in_frame) m_einf = 0;
         if (!data_in) m_z++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (ais !== m_ais) begin
            bad++;
            $display("FAIL %s model compare at cycle %0d: actual=%b expected=%b",
                     cur_req, cycles, ais, m_ais);
         end
      end
   end

   task automatic check(input string req, input logic expected, input string what);
      total++;
      if (ais !== expected) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, ais, expected);
      end
   endtask

   task automatic drive(input logic en, input logic d, input logic pay, input logic cb,
                        input logic xb, input logic fs, input logic ms, input logic inf);
      bit_en = en; data_in = d; is_payload = pay; is_cbit = cb; is_xbit = xb;
      frame_start = fs; mframe_start = ms; in_frame = inf;
      @(negedge clk);
   endtask

   // R10: disabled cycles carry junk that must be ignored
   task automatic idle(input int n);
      for (int k = 0; k < n; k++)
         drive(1'b0, 1'($urandom), 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
   endtask

   // kinds: 0 good/first payload 1, 1 good/first payload 0, 2 payload break,
   //        3 C-bit set, 4 X-bit cleared, 5 in_frame dropped
   task automatic send_ds3(input int kind, input int gap);
      int  pidx;
      bit  first;
      pidx  = 0;
      first = (kind == 1) ? 1'b0 : 1'b1;
      for (int i = 0; i < 24; i++) begin
         logic d, xb, cb, pay, inf;
         xb  = (i == 0 || i == 12);
         cb  = (i == 1 || i == 2 || i == 13);
         pay = !(xb || cb);
         inf = !(kind == 5 && i == 7);
         if (xb)      d = (kind == 4 && i == 12) ? 1'b0 : 1'b1;
         else if (cb) d = (kind == 3 && i == 13) ? 1'b1 : 1'b0;
         else begin
            d = (pidx % 2 == 0) ? first : !first;
            if (kind == 2 && pidx == 6) d = !d;
            pidx++;
         end
         if (gap > 0 && i == 5) idle(gap);
         drive(1'b1, d, pay, cb, xb, (i == 0 || i == 12), (i == 0), inf);
      end
   endtask

   task automatic send_e3(input int zeros);
      for (int i = 0; i < 24; i++)
         drive(1'b1, (i < zeros) ? 1'b0 : 1'b1, 1'b0, 1'b0, 1'b0, (i == 0), 1'b0, 1'b1);
   endtask

   task automatic change_mode(input logic m);
      mode_sel = m;
      idle(2);
   endtask

   always @(posedge clk) begin
      if (cycles > 100000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL R10 watchdog: actual=%0d cycles expected<=100000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R1", 1'b0, "flag during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b0, "flag after reset");

      // R2 R3 R10: 63 frames sent, 62 judged, mixed phases and junk gaps
      cur_req = "R2";
      for (int f = 0; f < 63; f++) send_ds3(f % 2, (f % 7 == 3) ? 3 : 0);
      check("R2", 1'b0, "62 judged M-frames");
      send_ds3(1, 0);
      check("R2", 1'b1, "63 judged M-frames");
      check("R3", 1'b1, "either first payload phase qualifies");

      // R5: clear needs two consecutive failures
      cur_req = "R5";
      send_ds3(2, 0); send_ds3(0, 0); send_ds3(2, 0); send_ds3(0, 0);
      check("R5", 1'b1, "isolated failures do not clear");
      send_ds3(2, 0); send_ds3(2, 0);
      check("R5", 1'b1, "one judged failure of two");
      send_ds3(0, 0);
      check("R5", 1'b0, "two consecutive failures clear");
      check("R3", 1'b0, "payload break is non-qualifying");

      // R4: a C-bit fault restarts the run
      cur_req = "R4";
      for (int f = 0; f < 39; f++) send_ds3(0, 0);
      send_ds3(3, 0);
      for (int f = 0; f < 63; f++) send_ds3(1, 0);
      check("R4", 1'b0, "run restarted by C-bit fault");
      send_ds3(0, 0);
      check("R4", 1'b1, "63 after C-bit fault");

      // R4 R9: X-bit fault then in_frame loss clear the flag
      cur_req = "R9";
      send_ds3(4, 0); send_ds3(5, 0); send_ds3(0, 0);
      check("R9", 1'b0, "X-bit and in_frame faults clear");
      for (int f = 0; f < 63; f++) send_ds3(0, 0);
      check("R4", 1'b1, "set again after faults");

      // R8: mode change clears
      cur_req = "R8";
      change_mode(1'b1);
      check("R8", 1'b0, "switch to E3 clears flag");

      // R6 R7: E3 rule
      cur_req = "R6";
      send_e3(7); send_e3(7);
      check("R6", 1'b0, "one judged E3 frame");
      send_e3(0);
      check("R6", 1'b1, "two frames with 7 zeros set");
      send_e3(8);
      check("R6", 1'b1, "flag holds before bad frame is judged");
      cur_req = "R7";
      send_e3(1);
      check("R7", 1'b0, "single 8-zero frame clears");
      cur_req = "R6";
      send_e3(9); send_e3(2); send_e3(5);
      check("R6", 1'b0, "non-consecutive good frames");
      send_e3(5);
      check("R6", 1'b1, "consecutive good frames set");

      // R8: back to DS3, flag clears and partial frame is not judged
      cur_req = "R8";
      change_mode(1'b0);
      check("R8", 1'b0, "switch to DS3 clears flag");
      for (int f = 0; f < 64; f++) send_ds3(0, 0);
      check("R8", 1'b1, "fresh run after mode change");

      idle(3);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule